// File: doc/BRIEF.md
# Trap-Word-Immediate Condition and Routing Unit

This unit sits beside the execute stage of a 32-bit core. Each cycle it may receive an instruction word and the value already read from the source register that the word names. If the primary opcode marks a trap-word-immediate instruction, the unit sign-extends the 16-bit immediate to 32 bits. It then runs up to five comparisons between the register value and the extended immediate, as selected by a 5-bit condition mask. If any selected comparison is true, the instruction traps.

A trap goes to one of three places: a program interrupt, a debug interrupt, or a halted debug-stop state. The choice depends on three debug-control enables (trap debug enable, internal debug mode, external debug mode) and on the debug-exception enable from the machine state. The unit also keeps two sticky bits. The first is an imprecise-debug-event flag that only a clear pulse removes. The second is the halted flag, which only a resume pulse removes. While the unit is halted it stalls the pipeline and ignores instructions.

Top module: `trap_route_unit`

## Requirements
- R1: Bits are numbered big-endian, with bit 0 as the MSB. Word bits 0..5 (insn[31:26]) hold the primary opcode, and 3 means trap-word-immediate. Bits 6..10 (insn[25:21]) hold the mask and bits 11..15 (insn[20:16]) hold the register index, which is output on `src_sel`. Bits 16..31 (insn[15:0]) hold the immediate. If the opcode is not 3 or `insn_valid` is low, the instruction has no effect on any output or state.
- R2: The immediate is sign-extended to 32 bits before comparison. With immediate 0xFFFF and the equal test selected, a register value of 0xFFFFFFFF traps and a value of 0x0000FFFF does not.
- R3: Mask bit 0 (insn[25]) selects signed less-than, bit 1 (insn[24]) signed greater-than, bit 2 (insn[23]) equal, bit 3 (insn[22]) unsigned less-than and bit 4 (insn[21]) unsigned greater-than. The instruction traps when any selected test is true. A zero mask never traps, and an all-ones mask always traps.
- R4: A trap raises a program interrupt when the trap debug enable is 0, or when both the internal and external debug mode enables are 0.
- R5: When the trap debug enable and the external debug mode enable are both 1, a trap sets the halted flag and raises no interrupt. It also sets the imprecise flag if the internal debug mode enable is 1 and the debug-exception enable is 0.
- R6: When the trap debug enable and the internal debug mode enable are 1 and the external debug mode enable is 0, the result depends on the debug-exception enable. If it is 1, a trap raises a debug interrupt. If it is 0, a trap raises a program interrupt and sets the imprecise flag.
- R7: `prog_irq` and `dbg_irq` are one-cycle pulses. They appear on the clock edge after the trapping instruction is presented, and they are never high together.
- R8: The imprecise flag stays set until `imprecise_clr` is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R9: `halted` stays set until `resume` is pulsed. While it is set, `stall` is high and instructions are ignored.
- R10: Synchronous reset clears `halted`, the imprecise flag and both interrupt pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Instruction word |
| src_value | input | 32 | Value of the register named by the word |
| dbg_trap_en | input | 1 | Trap debug enable |
| dbg_int_mode | input | 1 | Internal debug mode enable |
| dbg_ext_mode | input | 1 | External debug mode enable |
| msr_dbg_exc_en | input | 1 | Debug-exception enable from machine state |
| imprecise_clr | input | 1 | Software clear of the imprecise flag |
| resume | input | 1 | External resume from debug stop |
| src_sel | output | 5 | Register index field of the word |
| prog_irq | output | 1 | Program interrupt pulse |
| dbg_irq | output | 1 | Debug interrupt pulse |
| halted | output | 1 | Debug-stop state flag |
| stall | output | 1 | Pipeline stall while halted |
| imprecise_evt | output | 1 | Sticky imprecise-debug-event flag |

## Verification
A wrong comparison or a wrong mask-bit mapping shows up on the edge after the instruction. It appears as a missing or extra interrupt pulse, or as `halted` rising or failing to rise. A routing fault shows as the wrong pulse, or as a pulse where `halted` should have set. A broken sticky flag is also visible on the next edge. In that case `halted` or `imprecise_evt` drops without a resume or clear, or a halted unit still pulses an interrupt for a new instruction.

// File: rtl/trap_route_pkg.sv
package trap_route_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned MASK_W = 5;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned EXT_W  = WORD_W - IMM_W;
  localparam logic [OPC_W-1:0] OPC_TRAP_IMM = OPC_W'(3);

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_PROG = 2'd1,
    RT_DBG  = 2'd2,
    RT_HALT = 2'd3
  } route_e;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [MASK_W-1:0] mask;
    logic [IDX_W-1:0]  idx;
    logic [IMM_W-1:0]  imm;
  } insn_t;

  function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] i);
    return {{EXT_W{i[IMM_W-1]}}, i};
  endfunction

  // Test results, laid out to match the mask field:
  // [4]=slt [3]=sgt [2]=eq [1]=ult [0]=ugt
  function automatic logic [MASK_W-1:0] test_vector(input logic [WORD_W-1:0] a,
                                                    input logic [WORD_W-1:0] b);
    logic [MASK_W-1:0] v;
    v[4] = $signed(a) < $signed(b);
    v[3] = $signed(a) > $signed(b);
    v[2] = a == b;
    v[1] = a < b;
    v[0] = a > b;
    return v;
  endfunction
endpackage

// File: rtl/trap_decode.sv
module trap_decode
  import trap_route_pkg::*;
(
  input  logic [WORD_W-1:0] insn_word,
  input  logic              insn_valid,
  input  logic              halted,
  output logic              accept,
  output logic [MASK_W-1:0] mask,
  output logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] imm_ext
);
  insn_t f;
  always_comb begin
    f       = insn_t'(insn_word);
    accept  = insn_valid && !halted && (f.opc == OPC_TRAP_IMM);
    mask    = f.mask;
    idx     = f.idx;
    imm_ext = sext_imm(f.imm);
  end
endmodule

// File: rtl/trap_cond_eval.sv
module trap_cond_eval
  import trap_route_pkg::*;
(
  input  logic              accept,
  input  logic [MASK_W-1:0] mask,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [MASK_W-1:0] hits,
  output logic              fire
);
  always_comb begin
    hits = test_vector(a, b) & mask;
    fire = accept && (|hits);
  end
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trap_route_pkg::*;
(
  input  logic   fire,
  input  logic   trap_en,
  input  logic   int_mode,
  input  logic   ext_mode,
  input  logic   exc_en,
  output route_e route,
  output logic   set_imprecise
);
  always_comb begin
    route         = RT_NONE;
    set_imprecise = 1'b0;
    if (fire) begin
      if (!trap_en || (!int_mode && !ext_mode)) begin
        route = RT_PROG;
      end else if (ext_mode) begin
        route         = RT_HALT;
        set_imprecise = int_mode && !exc_en;
      end else if (exc_en) begin
        route = RT_DBG;
      end else begin
        route         = RT_PROG;
        set_imprecise = 1'b1;
      end
    end
  end
endmodule

// File: rtl/trap_route_unit.sv
module trap_route_unit
  import trap_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [WORD_W-1:0] insn_word,
  input  logic [WORD_W-1:0] src_value,
  input  logic              dbg_trap_en,
  input  logic              dbg_int_mode,
  input  logic              dbg_ext_mode,
  input  logic              msr_dbg_exc_en,
  input  logic              imprecise_clr,
  input  logic              resume,
  output logic [IDX_W-1:0]  src_sel,
  output logic              prog_irq,
  output logic              dbg_irq,
  output logic              halted,
  output logic              stall,
  output logic              imprecise_evt
);
  logic              accept;
  logic [MASK_W-1:0] mask;
  logic [WORD_W-1:0] imm_ext;
  logic [MASK_W-1:0] hits;
  logic              trap_fire;
  route_e            route_sel;
  logic              set_imprecise;

  trap_decode u_dec (
    .insn_word(insn_word), .insn_valid(insn_valid), .halted(halted),
    .accept(accept), .mask(mask), .idx(src_sel), .imm_ext(imm_ext)
  );

  trap_cond_eval u_cond (
    .accept(accept), .mask(mask), .a(src_value), .b(imm_ext),
    .hits(hits), .fire(trap_fire)
  );

  trap_dispatch u_disp (
    .fire(trap_fire), .trap_en(dbg_trap_en), .int_mode(dbg_int_mode),
    .ext_mode(dbg_ext_mode), .exc_en(msr_dbg_exc_en),
    .route(route_sel), .set_imprecise(set_imprecise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_irq      <= 1'b0;
      dbg_irq       <= 1'b0;
      halted        <= 1'b0;
      imprecise_evt <= 1'b0;
    end else begin
      prog_irq      <= (route_sel == RT_PROG);
      dbg_irq       <= (route_sel == RT_DBG);
      halted        <= halted ? !resume : (route_sel == RT_HALT);
      imprecise_evt <= set_imprecise || (imprecise_evt && !imprecise_clr);
    end
  end

  assign stall = halted;
endmodule

// File: rtl/trap_route_chk.sv
module trap_route_chk
  import trap_route_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   insn_valid,
  input logic   dbg_trap_en,
  input logic   dbg_int_mode,
  input logic   dbg_ext_mode,
  input logic   msr_dbg_exc_en,
  input logic   imprecise_clr,
  input logic   resume,
  input logic   prog_irq,
  input logic   dbg_irq,
  input logic   halted,
  input logic   imprecise_evt,
  input logic   trap_fire
);
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(prog_irq && dbg_irq)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=> !prog_irq && !dbg_irq); // R1
  AST_HALT_IGNORES: assert property (@(posedge clk) disable iff (rst)
    halted |=> !prog_irq && !dbg_irq); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted && !resume |=> halted); // R9
  AST_IMP_STICKY: assert property (@(posedge clk) disable iff (rst)
    imprecise_evt && !imprecise_clr |=> imprecise_evt); // R8
  AST_EXT_HALTS: assert property (@(posedge clk) disable iff (rst)
    trap_fire && dbg_trap_en && dbg_ext_mode |=> halted && !prog_irq && !dbg_irq); // R5
  AST_DBG_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    trap_fire && !(dbg_trap_en && dbg_int_mode && !dbg_ext_mode && msr_dbg_exc_en)
    |=> !dbg_irq); // R6
  AST_PLAIN_PROG: assert property (@(posedge clk) disable iff (rst)
    trap_fire && !dbg_trap_en |=> prog_irq); // R4
endmodule

bind trap_route_unit trap_route_chk u_chk (
  .clk(clk), .rst(rst), .insn_valid(insn_valid),
  .dbg_trap_en(dbg_trap_en), .dbg_int_mode(dbg_int_mode),
  .dbg_ext_mode(dbg_ext_mode), .msr_dbg_exc_en(msr_dbg_exc_en),
  .imprecise_clr(imprecise_clr), .resume(resume),
  .prog_irq(prog_irq), .dbg_irq(dbg_irq), .halted(halted),
  .imprecise_evt(imprecise_evt), .trap_fire(trap_fire)
);

// File: tb/sim_trap_route_unit.sv
`timescale 1ns/1ps
module sim_trap_route_unit;
  logic clk = 1'b0;
  logic rst;
  logic insn_valid;
  logic [31:0] insn_word, src_value;
  logic dbg_trap_en, dbg_int_mode, dbg_ext_mode, msr_dbg_exc_en;
  logic imprecise_clr, resume;
  logic [4:0] src_sel;
  logic prog_irq, dbg_irq, halted, stall, imprecise_evt;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic m_halt = 0, m_imp = 0, m_prog = 0, m_dbg = 0;

  always #5 clk = ~clk;

  trap_route_unit u0 (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .src_value(src_value), .dbg_trap_en(dbg_trap_en), .dbg_int_mode(dbg_int_mode),
    .dbg_ext_mode(dbg_ext_mode), .msr_dbg_exc_en(msr_dbg_exc_en),
    .imprecise_clr(imprecise_clr), .resume(resume), .src_sel(src_sel),
    .prog_irq(prog_irq), .dbg_irq(dbg_irq), .halted(halted), .stall(stall),
    .imprecise_evt(imprecise_evt)
  );

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] to,
                                     input logic [4:0] ra, input logic [15:0] si);
    return {opc, to, ra, si};
  endfunction

  // Sign-flip trick for signed order; immediate extension by arithmetic shift.
  function automatic logic tb_fire(input logic [31:0] w, input logic [31:0] a);
    logic [31:0] b;
    logic [4:0] to;
    logic slt, sgt;
    b   = 32'($signed({w[15:0], 16'h0}) >>> 16);
    to  = w[25:21];
    slt = (a ^ 32'h8000_0000) < (b ^ 32'h8000_0000);
    sgt = (b ^ 32'h8000_0000) < (a ^ 32'h8000_0000);
    return (to[4] & slt) | (to[3] & sgt) | (to[2] & (a == b)) |
           (to[1] & (a < b)) | (to[0] & (b < a));
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input logic v, input logic [31:0] w,
                      input logic [31:0] a, input logic [3:0] en,
                      input logic clr, input logic res);
    logic fire, p, d, h, s;
    insn_valid = v; insn_word = w; src_value = a;
    {dbg_trap_en, dbg_int_mode, dbg_ext_mode, msr_dbg_exc_en} = en;
    imprecise_clr = clr; resume = res;
    fire = v && !m_halt && (w[31:26] == 6'd3) && tb_fire(w, a);
    p = 0; d = 0; h = 0; s = 0;
    if (fire) begin
      if (!en[3] || (!en[2] && !en[1])) p = 1;
      else if (en[1]) begin h = 1; s = en[2] && !en[0]; end
      else if (en[0]) d = 1;
      else begin p = 1; s = 1; end
    end
    m_prog = p; m_dbg = d;
    m_halt = m_halt ? !res : h;
    m_imp  = s | (m_imp & !clr);
    @(posedge clk);
    @(negedge clk);
    chk(req, "prog_irq", prog_irq, m_prog);
    chk(req, "dbg_irq", dbg_irq, m_dbg);
    chk(req, "halted", halted, m_halt);
    chk(req, "stall", stall, m_halt);
    chk(req, "imprecise_evt", imprecise_evt, m_imp);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pool [8];
    pool = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
             32'h0000_7FFF, 32'hFFFF_8000, 32'h0000_FFFF};
    void'($urandom(32'd1234));
    rst = 1; insn_valid = 0; insn_word = 0; src_value = 0;
    dbg_trap_en = 0; dbg_int_mode = 0; dbg_ext_mode = 0; msr_dbg_exc_en = 0;
    imprecise_clr = 0; resume = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", "prog_irq", prog_irq, 0);
    chk("R10", "dbg_irq", dbg_irq, 0);
    chk("R10", "halted", halted, 0);
    chk("R10", "imprecise_evt", imprecise_evt, 0);
    rst = 0;
    // R1 field position of register index
    insn_word = mk(6'd3, 5'h0, 5'd19, 16'h0); #1;
    chk("R1", "src_sel==19", src_sel == 5'd19, 1);
    // R1 wrong opcode / invalid
    step("R1", 1, mk(6'd4, 5'h1F, 5'd1, 16'h0), 32'h5, 4'b0000, 0, 0);
    step("R1", 0, mk(6'd3, 5'h1F, 5'd1, 16'h0), 32'h5, 4'b0000, 0, 0);
    // R2 sign extension
    step("R2", 1, mk(6'd3, 5'b00100, 5'd0, 16'hFFFF), 32'hFFFF_FFFF, 4'b0000, 0, 0);
    step("R2", 1, mk(6'd3, 5'b00100, 5'd0, 16'hFFFF), 32'h0000_FFFF, 4'b0000, 0, 0);
    // R3 each mask bit, zero and full mask
    step("R3", 1, mk(6'd3, 5'b10000, 5'd0, 16'h0001), 32'hFFFF_FFFF, 4'b0000, 0, 0);
    step("R3", 1, mk(6'd3, 5'b00010, 5'd0, 16'h0001), 32'hFFFF_FFFF, 4'b0000, 0, 0);
    step("R3", 1, mk(6'd3, 5'b00001, 5'd0, 16'h0001), 32'hFFFF_FFFF, 4'b0000, 0, 0);
    step("R3", 1, mk(6'd3, 5'b01000, 5'd0, 16'h0001), 32'h0000_0002, 4'b0000, 0, 0);
    step("R3", 1, mk(6'd3, 5'b00000, 5'd0, 16'h0001), 32'h0000_0001, 4'b0000, 0, 0);
    step("R3", 1, mk(6'd3, 5'b11111, 5'd0, 16'h1234), 32'h0000_1234, 4'b0000, 0, 0);
    // R4 enables with both modes off
    step("R4", 1, mk(6'd3, 5'h1F, 5'd0, 16'h0), 32'h0, 4'b1001, 0, 0);
    // R6 internal mode, exceptions on then off
    step("R6", 1, mk(6'd3, 5'h1F, 5'd0, 16'h0), 32'h0, 4'b1101, 0, 0);
    step("R6", 1, mk(6'd3, 5'h1F, 5'd0, 16'h0), 32'h0, 4'b1100, 0, 0);
    // R8 clear, then set and clear together
    step("R8", 0, 32'h0, 32'h0, 4'b0000, 1, 0);
    step("R8", 1, mk(6'd3, 5'h1F, 5'd0, 16'h0), 32'h0, 4'b1100, 1, 0);
    step("R8", 0, 32'h0, 32'h0, 4'b0000, 1, 0);
    // R5 external halt with imprecise set, R9 ignore while halted
    step("R5", 1, mk(6'd3, 5'h1F, 5'd0, 16'h0), 32'h0, 4'b1110, 0, 0);
    step("R9", 1, mk(6'd3, 5'h1F, 5'd0, 16'h0), 32'h0, 4'b0000, 0, 0);
    step("R9", 0, 32'h0, 32'h0, 4'b0000, 0, 1);
    step("R5", 1, mk(6'd3, 5'h1F, 5'd0, 16'h0), 32'h0, 4'b1011, 1, 0);
    step("R9", 0, 32'h0, 32'h0, 4'b0000, 0, 1);
    // R7 pulse lasts one cycle
    step("R7", 1, mk(6'd3, 5'h1F, 5'd0, 16'h0), 32'h0, 4'b0000, 0, 0);
    step("R7", 0, 32'h0, 32'h0, 4'b0000, 0, 0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] opc;
      logic [15:0] si;
      logic [31:0] a;
      opc = ($urandom % 8 != 0) ? 6'd3 : 6'($urandom);
      si  = ($urandom % 2) ? 16'($urandom) : pool[$urandom % 8][15:0];
      a   = ($urandom % 3 == 0) ? 32'($urandom)
          : (($urandom % 2) ? {{16{si[15]}}, si} : pool[$urandom % 8]);
      step("R3", ($urandom % 5 != 0), mk(opc, 5'($urandom), 5'($urandom), si), a,
           4'($urandom), ($urandom % 10 == 0), ($urandom % 4 == 0));
    end
    // R10 reset clears sticky state
    step("R5", 1, mk(6'd3, 5'h1F, 5'd0, 16'h0), 32'h0, 4'b1110, 0, 0);
    rst = 1;
    @(posedge clk); @(negedge clk);
    chk("R10", "halted after reset", halted, 0);
    chk("R10", "imprecise after reset", imprecise_evt, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule